// File: doc/BRIEF.md
# Internal Data Space Controller for an 8-bit Microcontroller Core

This block holds the 256-byte internal data space of an 8-bit accumulator-style core and services the core's byte, bit and register requests to it. Each request carries an access mode, an 8-bit address and, for writes, a byte or a single bit. The controller sends the request to one of four places: the lower RAM, the upper RAM, a locally held special register, or an external special-register bus. The upper half of the address range resolves differently by mode. Direct byte accesses there go to the special registers. Indirect byte accesses there go to a separate 128-byte RAM.

Register-mode accesses name R0..R7. The controller places them in one of four 8-byte banks at the bottom of RAM, using two bank-select bits of the status word. Bit accesses reach a 16-byte bit field in RAM or the bit-addressable special registers, and a bit write is a read-modify-write of the containing byte finished in the request cycle. The controller also presents a 16-bit external address for register-indirect external moves. A local page register gives the upper byte and the selected pointer register (R0 or R1) gives the lower byte.

The request path is a two-state machine. `S_IDLE` moves to `S_RESP` on `T_READ` (a read request is accepted). `S_RESP` moves to `S_RESP` on `T_READ_AGAIN` (a read request arrives while a response is shown) and back to `S_IDLE` on `T_DONE` (no read request). `S_IDLE` stays in `S_IDLE` on `T_STAY` (no read request). The response strobe is high only in `S_RESP`.

Top module: `idata_ctrl`

## Requirements
- R1: After reset all 256 RAM bytes, the status word and the page register read 0x00, `rd_valid` is low and `xaddr` is 0x0000.
- R2: Modes are encoded as `req_mode` 00 = direct byte, 01 = indirect byte, 10 = bit, 11 = register. For addresses 0x00..0x7F the direct and indirect byte modes reach the same RAM byte.
- R3: An indirect byte access to 0x80..0xFF reaches an upper RAM separate from the special registers, and it never raises `sfr_rd` or `sfr_wr`.
- R4: A direct byte access to 0x80..0xFF other than 0xD0 and 0xBF appears on the external bus with `sfr_addr` equal to the request address, `sfr_wr` high for a write carrying `sfr_wdata`, and `sfr_rd` high for a read.
- R5: A read from an external special-register address for which `sfr_hit` is low returns 0x00.
- R6: Register mode with `req_addr[2:0]` = n reaches RAM byte bank*8+n, where bank is status-word bits [4:3].
- R7: A bit address b below 0x80 selects RAM byte 0x20+b[6:3], bit b[2:0]. A bit write changes only that bit, and a bit read returns the bit in `rd_data[0]` with bits [7:1] zero.
- R8: A bit address b of 0x80 or above selects special-register byte {b[7:3],000}, bit b[2:0]. On the external bus a bit write raises `sfr_rd` and `sfr_wr` in the same cycle with only that bit changed. The status word is also bit writable.
- R9: `rd_valid` is high exactly in the cycle after a read request is accepted, and `rd_data` then carries the value read. It stays low after writes and idle cycles.
- R10: `xaddr` equals {page register, R`movx_ri` of the active bank}. The page register is written and read by direct byte access at 0xBF.
- R11: The status word is held locally at direct address 0xD0. Accesses to it never raise `sfr_rd` or `sfr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Access mode (see R2) |
| req_addr | input | 8 | Byte address, bit address or register number |
| req_wdata | input | 8 | Byte write data |
| req_wbit | input | 1 | Bit write value |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 8 | Read response data |
| sfr_addr | output | 8 | External special-register address |
| sfr_rd | output | 1 | External special-register read strobe |
| sfr_wr | output | 1 | External special-register write strobe |
| sfr_wdata | output | 8 | External special-register write data |
| sfr_rdata | input | 8 | External special-register read data, combinational from `sfr_addr` |
| sfr_hit | input | 1 | External register exists at `sfr_addr` |
| movx_ri | input | 1 | Pointer register select for the external address (0 = R0, 1 = R1) |
| xaddr | output | 16 | External move address |

## Verification
The bench writes one value directly to 0x90 and a different value indirectly to the same address, then reads both back. A controller that merged the upper RAM with the special registers would return the later value for both. The bench switches the status-word bank bits through all four banks and reads each register back by direct address. A wrong bank shift or a stale bank would put the data at the wrong byte. It sets and clears single bits in the RAM bit field, in an external register and in the status word. A wrong byte/bit split or a missing read-modify-write would change neighbouring bits. It also checks that a pin driving junk for an absent register still yields 0x00, and that the external address follows both the page register and the pointer select.

// File: rtl/idata_pkg.sv
package idata_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        M_DIRECT   = 2'b00,
        M_INDIRECT = 2'b01,
        M_BIT      = 2'b10,
        M_REG      = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        TGT_RAM,
        TGT_PSW,
        TGT_PAGE,
        TGT_EXT
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] ram_idx;
        logic [ADDR_W-1:0] sfr_addr;
        logic              is_bit;
        logic [2:0]        bit_pos;
    } dec_t;
endpackage

// File: rtl/idata_decode.sv
module idata_decode
    import idata_pkg::*;
#(
    parameter logic [7:0] PSW_ADDR    = 8'hD0,
    parameter logic [7:0] PAGE_ADDR   = 8'hBF,
    parameter logic [7:0] BITRAM_BASE = 8'h20
) (
    input  acc_mode_e   mode,
    input  logic [7:0]  addr,
    input  logic [1:0]  bank,
    output dec_t        dec
);
    function automatic tgt_e classify(input logic [7:0] a);
        if (a == PSW_ADDR)       return TGT_PSW;
        else if (a == PAGE_ADDR) return TGT_PAGE;
        else                     return TGT_EXT;
    endfunction

    always_comb begin
        dec         = '0;
        dec.tgt     = TGT_RAM;
        dec.bit_pos = addr[2:0];
        unique case (mode)
            M_DIRECT: begin
                if (addr[7]) begin
                    dec.tgt      = classify(addr);
                    dec.sfr_addr = addr;
                end else begin
                    dec.ram_idx  = addr;
                end
            end
            M_INDIRECT: begin
                dec.ram_idx = addr;
            end
            M_BIT: begin
                dec.is_bit = 1'b1;
                if (addr[7]) begin
                    dec.tgt      = classify({addr[7:3], 3'b000});
                    dec.sfr_addr = {addr[7:3], 3'b000};
                end else begin
                    dec.ram_idx  = BITRAM_BASE + {4'b0000, addr[6:3]};
                end
            end
            M_REG: begin
                dec.ram_idx = {3'b000, bank, addr[2:0]};
            end
        endcase
    end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/idata_lsfr.sv
module idata_lsfr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_psw,
    input  logic              we_page,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] psw,
    output logic [DATA_W-1:0] page
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psw  <= '0;
            page <= '0;
        end else begin
            if (we_psw)  psw  <= wdata;
            if (we_page) page <= wdata;
        end
    end
endmodule

// File: rtl/idata_ctrl.sv
module idata_ctrl
    import idata_pkg::*;
#(
    parameter logic [7:0] PSW_ADDR  = 8'hD0,
    parameter logic [7:0] PAGE_ADDR = 8'hBF,
    parameter int         BANK_LSB  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_mode,
    input  logic [7:0]  req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        req_wbit,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic [7:0]  sfr_addr,
    output logic        sfr_rd,
    output logic        sfr_wr,
    output logic [7:0]  sfr_wdata,
    input  logic [7:0]  sfr_rdata,
    input  logic        sfr_hit,
    input  logic        movx_ri,
    output logic [15:0] xaddr
);
    localparam int RAM_DEPTH = 1 << ADDR_W;

    typedef enum logic {S_IDLE, S_RESP} state_e;
    state_e state_q, state_d;

    logic [DATA_W-1:0] psw, page;
    logic [1:0]        bank;
    dec_t              dec;
    logic [DATA_W-1:0] ram_rd, ram_ptr;
    logic [DATA_W-1:0] old_byte, new_byte, read_val;
    logic              wr_req, rd_req;
    logic [7:0]        ptr_idx;

    assign bank   = psw[BANK_LSB+1:BANK_LSB];
    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    idata_decode #(
        .PSW_ADDR  (PSW_ADDR),
        .PAGE_ADDR (PAGE_ADDR)
    ) u_dec (
        .mode (acc_mode_e'(req_mode)),
        .addr (req_addr),
        .bank (bank),
        .dec  (dec)
    );

    assign ptr_idx = {3'b000, bank, 2'b00, movx_ri};

    idata_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_req && dec.tgt == TGT_RAM),
        .widx    (dec.ram_idx),
        .wdata   (new_byte),
        .ridx_a  (dec.ram_idx),
        .rdata_a (ram_rd),
        .ridx_b  (ptr_idx),
        .rdata_b (ram_ptr)
    );

    idata_lsfr #(.DATA_W(DATA_W)) u_lsfr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_psw  (wr_req && dec.tgt == TGT_PSW),
        .we_page (wr_req && dec.tgt == TGT_PAGE),
        .wdata   (new_byte),
        .psw     (psw),
        .page    (page)
    );

    // Source selection and bit merge
    always_comb begin
        unique case (dec.tgt)
            TGT_RAM:  old_byte = ram_rd;
            TGT_PSW:  old_byte = psw;
            TGT_PAGE: old_byte = page;
            TGT_EXT:  old_byte = sfr_hit ? sfr_rdata : '0;
        endcase
        if (dec.is_bit) begin
            new_byte = (old_byte & ~(8'(1) << dec.bit_pos))
                     | (8'(req_wbit) << dec.bit_pos);
            read_val = {7'b0, old_byte[dec.bit_pos]};
        end else begin
            new_byte = req_wdata;
            read_val = old_byte;
        end
    end

    assign sfr_addr  = dec.sfr_addr;
    assign sfr_rd    = req_valid && dec.tgt == TGT_EXT && (!req_write || dec.is_bit);
    assign sfr_wr    = wr_req && dec.tgt == TGT_EXT;
    assign sfr_wdata = new_byte;
    assign xaddr     = {page, ram_ptr};

    // Next-state logic: T_READ, T_READ_AGAIN, T_DONE, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = rd_req ? S_RESP : S_IDLE;
            S_RESP: state_d = rd_req ? S_RESP : S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output process: response data captured with the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= read_val;
    end

    assign rd_valid = (state_q == S_RESP);
endmodule

// File: rtl/idata_ctrl_chk.sv
module idata_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_mode,
    input logic [7:0]  req_addr,
    input logic [7:0]  req_wdata,
    input logic        rd_valid,
    input logic [7:0]  sfr_addr,
    input logic        sfr_rd,
    input logic        sfr_wr,
    input logic [15:0] xaddr
);
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    a_r3_indirect_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01) |-> (!sfr_rd && !sfr_wr));

    a_r8_bit_bus_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((sfr_rd || sfr_wr) && req_mode == 2'b10) |-> (sfr_addr[2:0] == 3'b000));

    a_r8_bit_write_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && req_mode == 2'b10) |-> sfr_rd);

    a_r4_write_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> (req_valid && req_write));

    a_r11_psw_local: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00 && req_addr == 8'hD0) |-> (!sfr_rd && !sfr_wr));

    a_r10_page_to_xaddr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_mode == 2'b00 && req_addr == 8'hBF)
        |=> (xaddr[15:8] == $past(req_wdata)));
endmodule

bind idata_ctrl idata_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mode  (req_mode),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .xaddr     (xaddr)
);

// File: tb/idata_ctrl_tb.sv
module idata_ctrl_tb;
    localparam logic [1:0] MD = 2'b00, MI = 2'b01, MB = 2'b10, MR = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wbit = 1'b0, movx_ri = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [7:0]  req_addr = '0, req_wdata = '0;
    logic        rd_valid, sfr_rd, sfr_wr, sfr_hit;
    logic [7:0]  rd_data, sfr_addr, sfr_wdata, sfr_rdata;
    logic [15:0] xaddr;

    int errors = 0;
    int checks = 0;
    logic [7:0] ext_mem [256];

    always #10 clk = ~clk;

    idata_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wbit(req_wbit), .rd_valid(rd_valid), .rd_data(rd_data),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
        .movx_ri(movx_ri), .xaddr(xaddr)
    );

    // External register model: only 0x90 and 0x99 exist
    function automatic logic ext_exists(input logic [7:0] a);
        return (a == 8'h90) || (a == 8'h99);
    endfunction

    assign sfr_hit   = ext_exists(sfr_addr);
    assign sfr_rdata = sfr_hit ? ext_mem[sfr_addr] : 8'hEE;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ext_mem[i] <= '0;
        end else if (sfr_wr && ext_exists(sfr_addr)) begin
            ext_mem[sfr_addr] <= sfr_wdata;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d, input logic b);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mode = m;
        req_addr = a; req_wdata = d; req_wbit = b;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] m, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mode = m; req_addr = a;
        @(negedge clk);
        chk(rd_valid === 1'b1, "R9 rd_valid after read", 16'(rd_valid), 16'h1);
        d = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(rd_valid === 1'b0, "R1 rd_valid low", 16'(rd_valid), 16'h0);
        chk(xaddr === 16'h0000, "R1 xaddr zero", xaddr, 16'h0);
        rd(MD, 8'h00, d);  chk(d === 8'h00, "R1 ram 0x00", 16'(d), 16'h0);
        rd(MI, 8'hFF, d);  chk(d === 8'h00, "R1 upper ram 0xFF", 16'(d), 16'h0);
        rd(MD, 8'hD0, d);  chk(d === 8'h00, "R1 status word", 16'(d), 16'h0);
    endtask

    task automatic t_low_alias();
        logic [7:0] d;
        wr(MD, 8'h45, 8'hA7, 1'b0);
        rd(MI, 8'h45, d);  chk(d === 8'hA7, "R2 direct->indirect", 16'(d), 16'hA7);
        wr(MI, 8'h7F, 8'h3C, 1'b0);
        rd(MD, 8'h7F, d);  chk(d === 8'h3C, "R2 indirect->direct", 16'(d), 16'h3C);
    endtask

    task automatic t_upper_split();
        logic [7:0] d;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mode = MD; req_addr = 8'h90; req_wdata = 8'h5A;
        #1;
        chk(sfr_wr === 1'b1 && sfr_addr === 8'h90, "R4 direct write on bus", {sfr_wr, 7'b0, sfr_addr}, 16'h8090);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mode = MI; req_addr = 8'h90; req_wdata = 8'hC3;
        #1;
        chk(sfr_wr === 1'b0 && sfr_rd === 1'b0, "R3 indirect no bus", {14'b0, sfr_rd, sfr_wr}, 16'h0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd(MI, 8'h90, d);  chk(d === 8'hC3, "R3 upper ram kept", 16'(d), 16'hC3);
        rd(MD, 8'h90, d);  chk(d === 8'h5A, "R4 sfr read", 16'(d), 16'h5A);
        chk(ext_mem[8'h90] === 8'h5A, "R4 ext model", 16'(ext_mem[8'h90]), 16'h5A);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        wr(MD, 8'hA0, 8'h77, 1'b0);
        rd(MD, 8'hA0, d);  chk(d === 8'h00, "R5 absent sfr reads zero", 16'(d), 16'h0);
    endtask

    task automatic t_banks();
        logic [7:0] d;
        for (int b = 0; b < 4; b++) begin
            wr(MD, 8'hD0, 8'(b << 3), 1'b0);
            wr(MR, 8'h05, 8'(8'h10 + b), 1'b0);
        end
        for (int b = 0; b < 4; b++) begin
            rd(MD, 8'(b * 8 + 5), d);
            chk(d === 8'(8'h10 + b), "R6 bank register location", 16'(d), 16'(8'h10 + b));
        end
        wr(MD, 8'hD0, 8'h10, 1'b0);
        rd(MR, 8'h05, d);  chk(d === 8'h12, "R6 register read bank 2", 16'(d), 16'h12);
    endtask

    task automatic t_ram_bits();
        logic [7:0] d;
        wr(MD, 8'h22, 8'hF0, 1'b0);
        wr(MB, 8'h13, 8'h00, 1'b1);
        wr(MB, 8'h17, 8'h00, 1'b0);
        rd(MD, 8'h22, d);  chk(d === 8'h78, "R7 ram bit set/clear", 16'(d), 16'h78);
        rd(MB, 8'h16, d);  chk(d === 8'h01, "R7 bit read one", 16'(d), 16'h1);
        rd(MB, 8'h17, d);  chk(d === 8'h00, "R7 bit read zero", 16'(d), 16'h0);
    endtask

    task automatic t_sfr_bits();
        logic [7:0] d;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mode = MB; req_addr = 8'h90; req_wbit = 1'b1;
        #1;
        chk(sfr_rd === 1'b1 && sfr_wr === 1'b1 && sfr_wdata === 8'h5B,
            "R8 bit write rmw strobes", {sfr_rd, sfr_wr, 6'b0, sfr_wdata}, 16'hC05B);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        wr(MB, 8'h94, 8'h00, 1'b0);
        rd(MD, 8'h90, d);  chk(d === 8'h4B, "R8 ext bit set/clear", 16'(d), 16'h4B);
        wr(MD, 8'hD0, 8'h00, 1'b0);
        wr(MB, 8'hD3, 8'h00, 1'b1);
        rd(MD, 8'hD0, d);  chk(d === 8'h08, "R8 status word bit set", 16'(d), 16'h08);
        rd(MB, 8'hD3, d);  chk(d === 8'h01, "R8 status word bit read", 16'(d), 16'h1);
    endtask

    task automatic t_psw_local();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mode = MD; req_addr = 8'hD0; req_wdata = 8'h10;
        #1;
        chk(sfr_wr === 1'b0 && sfr_rd === 1'b0, "R11 status word off bus", {14'b0, sfr_rd, sfr_wr}, 16'h0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_movx();
        logic [7:0] d;
        wr(MD, 8'hBF, 8'h12, 1'b0);
        wr(MR, 8'h01, 8'h34, 1'b0);
        wr(MR, 8'h00, 8'h56, 1'b0);
        @(negedge clk);
        movx_ri = 1'b1;
        #1;
        chk(xaddr === 16'h1234, "R10 xaddr via R1", xaddr, 16'h1234);
        movx_ri = 1'b0;
        #1;
        chk(xaddr === 16'h1256, "R10 xaddr via R0", xaddr, 16'h1256);
        rd(MD, 8'hBF, d);  chk(d === 8'h12, "R10 page readback", 16'(d), 16'h12);
    endtask

    task automatic t_latency();
        wr(MD, 8'h30, 8'h01, 1'b0);
        chk(rd_valid === 1'b0, "R9 no valid after write", 16'(rd_valid), 16'h0);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R9 no valid when idle", 16'(rd_valid), 16'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_low_alias();
                t_upper_split();
                t_unimpl();
                t_banks();
                t_ram_bits();
                t_sfr_bits();
                t_psw_local();
                t_movx();
                t_latency();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", 16'h0, 16'h1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule